// File: doc/BRIEF.md
# Time-Sliced Baud Enable Generator

This block makes the 16x-oversampling clock enable for a set of serial channels. It has one shared down-counter instead of one counter per channel. A slot pointer steps through the channels, one per clock. In each slot the block reads that channel's saved count, and either reloads it from the channel's divisor or decrements it. It fires the channel's enable when the count runs out, then writes the count back. The channel count is a parameter and may be 4, 8 or 16.

Counts are kept in channel visits, and each channel is visited once every channel-count clocks. The core clock therefore runs at channel count × 16 × the fastest baud rate. With a core clock of channel count × 1.8432 MHz, a divisor of 1 gives 115 200 baud, 12 gives 9600 baud and 384 gives 300 baud. The result comes out as a pulse `tick_o` together with the index `ch_o` of the channel it belongs to. The serial engines downstream cannot stall a bit period, so this output is a plain timed strobe. It has no ready signal and no back-pressure: a consumer that misses the pulse misses that sample. The divisor inputs are plain levels, and the block reads them at each slot.

Top module: `tsbaud_gen`

## Requirements
- R1: With a steady divisor D ≥ 1 on a channel, that channel's enable fires on every D-th visit, so consecutive enables for that channel are exactly D visits apart.
- R2: `ch_o` advances by one channel every clock, wraps from channel count − 1 to 0, and shows channel 0 on the first clock after reset is released.
- R3: While `rst_n` is low, `tick_o` is 0 and `ch_o` holds channel count − 1.
- R4: Visits are numbered from 0 after reset. Reset clears every saved count. A channel's visit 0 loads its divisor and never fires, so with a steady divisor D its first enable is at visit D.
- R5: When a channel's divisor differs from the value seen on its previous visit, the next visit reloads the new value without firing. The next enable then comes D_new visits later.
- R6: A divisor of 0 behaves exactly like a divisor of 1.
- R7: Channels are independent. Each channel's enables depend only on its own divisor, even when all channels use different divisors at once.
- R8: The output for a channel's visit appears one clock after its slot. Visit j of channel c shows on `ch_o`/`tick_o` after clock edge j × channel count + c + 1, counting from the edge after reset release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock, channel count × 16 × the highest baud rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_i | input | NUM_CH×DIV_W | Divisor per channel, channel c in bits [c×DIV_W +: DIV_W] |
| tick_o | output | 1 | Enable pulse for the channel shown on `ch_o` |
| ch_o | output | $clog2(NUM_CH) | Channel index of the current output slot |

## Verification
The assertions check the slot rotation, the silent first visit after reset, and the spacing between two enables of a channel whose divisor stayed put. They also check that a channel set to divisor 0 or 1 fires on every visit once it has started. The spacing check uses a visit counter per channel, so it covers every channel on every cycle. The bench scenarios are needed to show the exact visit numbers of the first enable, the reload without firing when a divisor changes mid-run, and the enable counts over a run.

// File: rtl/tsb_pkg.sv
package tsb_pkg;

  // What the shared engine does with the current channel's count in a slot.
  typedef enum logic [1:0] {
    ACT_LOAD = 2'd0,  // fresh divisor or cleared count: reload, stay quiet
    ACT_FIRE = 2'd1,  // count expired: pulse and reload
    ACT_STEP = 2'd2   // count running: decrement
  } tsb_act_e;

endpackage

// File: rtl/ts_slot_ctr.sv
module ts_slot_ctr #(
  parameter int NUM_CH = 4,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [CH_W-1:0] slot
);

  localparam logic [CH_W-1:0] LAST = CH_W'(NUM_CH - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slot <= '0;
    else if (slot == LAST) slot <= '0;
    else slot <= slot + 1'b1;
  end

endmodule

// File: rtl/ts_count_bank.sv
module ts_count_bank #(
  parameter int NUM_CH = 4,
  parameter int DIV_W  = 16,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CH_W-1:0]  idx,
  output logic [DIV_W-1:0] rd_cnt,
  output logic [DIV_W-1:0] rd_last,
  input  logic [DIV_W-1:0] wr_cnt,
  input  logic [DIV_W-1:0] wr_last
);

  logic [DIV_W-1:0] cnt_q  [NUM_CH];
  logic [DIV_W-1:0] last_q [NUM_CH];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q[c]  <= '0;
        last_q[c] <= '0;
      end else if (idx == CH_W'(c)) begin
        cnt_q[c]  <= wr_cnt;
        last_q[c] <= wr_last;
      end
    end
  end

  assign rd_cnt  = cnt_q[idx];
  assign rd_last = last_q[idx];

endmodule

// File: rtl/ts_div_engine.sv
module ts_div_engine
  import tsb_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic [DIV_W-1:0] cnt,
  input  logic [DIV_W-1:0] last,
  input  logic [DIV_W-1:0] div,
  output logic [DIV_W-1:0] nxt_cnt,
  output logic [DIV_W-1:0] nxt_last,
  output logic             fire
);

  tsb_act_e         act;
  logic [DIV_W-1:0] eff;

  assign eff = (div == '0) ? DIV_W'(1) : div;

  always_comb begin
    if (cnt == '0 || div != last) act = ACT_LOAD;
    else if (cnt == DIV_W'(1))    act = ACT_FIRE;
    else                          act = ACT_STEP;
  end

  always_comb begin
    unique case (act)
      ACT_LOAD: nxt_cnt = eff;
      ACT_FIRE: nxt_cnt = eff;
      default:  nxt_cnt = cnt - 1'b1;
    endcase
  end

  assign fire     = (act == ACT_FIRE);
  assign nxt_last = div;

endmodule

// File: rtl/tsbaud_gen.sv
module tsbaud_gen #(
  parameter int NUM_CH = 4,
  parameter int DIV_W  = 16,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_CH*DIV_W-1:0] div_i,
  output logic                    tick_o,
  output logic [CH_W-1:0]         ch_o
);

  if (NUM_CH != 4 && NUM_CH != 8 && NUM_CH != 16) begin : g_bad_count
    $error("tsbaud_gen: NUM_CH must be 4, 8 or 16");
  end

  logic [DIV_W-1:0] div_arr [NUM_CH];
  for (genvar c = 0; c < NUM_CH; c++) begin : g_unpack
    assign div_arr[c] = div_i[c*DIV_W +: DIV_W];
  end

  logic [CH_W-1:0]  slot;
  logic [DIV_W-1:0] cur_cnt, cur_last, nxt_cnt, nxt_last;
  logic             fire;

  ts_slot_ctr #(.NUM_CH(NUM_CH)) u_slot (
    .clk  (clk),
    .rst_n(rst_n),
    .slot (slot)
  );

  ts_count_bank #(.NUM_CH(NUM_CH), .DIV_W(DIV_W)) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .idx    (slot),
    .rd_cnt (cur_cnt),
    .rd_last(cur_last),
    .wr_cnt (nxt_cnt),
    .wr_last(nxt_last)
  );

  ts_div_engine #(.DIV_W(DIV_W)) u_eng (
    .cnt     (cur_cnt),
    .last    (cur_last),
    .div     (div_arr[slot]),
    .nxt_cnt (nxt_cnt),
    .nxt_last(nxt_last),
    .fire    (fire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_o <= 1'b0;
      ch_o   <= CH_W'(NUM_CH - 1);
    end else begin
      tick_o <= fire;
      ch_o   <= slot;
    end
  end

endmodule

// File: rtl/tsbaud_gen_chk.sv
module tsbaud_gen_chk #(
  parameter int NUM_CH = 4,
  parameter int DIV_W  = 16,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [NUM_CH*DIV_W-1:0] div_i,
  input logic                    tick_o,
  input logic [CH_W-1:0]         ch_o
);

  localparam logic [CH_W-1:0] LAST = CH_W'(NUM_CH - 1);

  logic [DIV_W-1:0] dv     [NUM_CH];
  logic [DIV_W-1:0] pdiv   [NUM_CH];
  logic [DIV_W-1:0] gap    [NUM_CH];
  logic [NUM_CH-1:0] have, stable, visited;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_dv
    assign dv[c] = div_i[c*DIV_W +: DIV_W];
  end

  // Per-channel window tracking in visits, observed at the outputs only.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have    <= '0;
      stable  <= '0;
      visited <= '0;
      for (int c = 0; c < NUM_CH; c++) begin
        pdiv[c] <= '0;
        gap[c]  <= '0;
      end
    end else begin
      visited[ch_o] <= 1'b1;
      if (tick_o) begin
        gap[ch_o]    <= '0;
        have[ch_o]   <= 1'b1;
        stable[ch_o] <= 1'b1;
      end else if (gap[ch_o] != '1) begin
        gap[ch_o] <= gap[ch_o] + 1'b1;
      end
      for (int c = 0; c < NUM_CH; c++) begin
        pdiv[c] <= dv[c];
        if (dv[c] != pdiv[c]) stable[c] <= 1'b0;
      end
    end
  end

  logic [DIV_W:0] eff_now;
  assign eff_now = (pdiv[ch_o] == '0) ? (DIV_W+1)'(1) : {1'b0, pdiv[ch_o]};

  // R2: rotation by one channel per clock with wrap
  p_rotate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (ch_o == (($past(ch_o) == LAST) ? '0 : $past(ch_o) + 1'b1)));

  // R4: first visit after reset never fires
  p_first_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !visited[ch_o] |-> !tick_o);

  // R1: steady divisor gives exact spacing between enables
  p_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && have[ch_o] && stable[ch_o]) |-> ({1'b0, gap[ch_o]} + 1'b1 == eff_now));

  // R6: divisor 0 or 1 fires on every visit once running
  p_div_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (have[ch_o] && stable[ch_o] && pdiv[ch_o] <= DIV_W'(1)) |-> tick_o);

endmodule

bind tsbaud_gen tsbaud_gen_chk #(.NUM_CH(NUM_CH), .DIV_W(DIV_W)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .div_i (div_i),
  .tick_o(tick_o),
  .ch_o  (ch_o)
);

// File: tb/tsbaud_gen_tb.sv
module tsbaud_gen_tb;

  localparam int NUM_CH = 4;
  localparam int DIV_W  = 16;
  localparam int CH_W   = $clog2(NUM_CH);
  localparam time CLK_PERIOD = 10ns;
  localparam int MAXV = 64;

  // Table: divisor applied to all channels, visits run, expected enables, first enable visit
  localparam int NV = 7;
  localparam int TV_DIV   [NV] = '{1, 2, 3, 12, 0, 5, 7};
  localparam int TV_VIS   [NV] = '{10, 10, 10, 40, 10, 11, 8};
  localparam int TV_CNT   [NV] = '{9, 4, 3, 3, 9, 2, 1};
  localparam int TV_FIRST [NV] = '{1, 2, 3, 12, 1, 5, 7};

  logic                    clk = 1'b0;
  logic                    rst_n = 1'b0;
  logic [NUM_CH*DIV_W-1:0] div_bus = '0;
  logic                    tick_o;
  logic [CH_W-1:0]         ch_o;

  int checks = 0;
  int errors = 0;
  int tick_cnt  [NUM_CH];
  int first_tick[NUM_CH];
  logic ticks_at [NUM_CH][MAXV];
  int rot_err;

  always #(CLK_PERIOD/2) clk = ~clk;

  tsbaud_gen #(.NUM_CH(NUM_CH), .DIV_W(DIV_W)) u_dut (
    .clk   (clk),
    .rst_n (rst_n),
    .div_i (div_bus),
    .tick_o(tick_o),
    .ch_o  (ch_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_div(input int c, input int d);
    div_bus[c*DIV_W +: DIV_W] = DIV_W'(d);
  endtask

  task automatic set_all(input int d);
    for (int c = 0; c < NUM_CH; c++) set_div(c, d);
  endtask

  // Hold reset for a few clocks, checking the reset state (R3), release at a falling edge.
  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) begin
      @(negedge clk);
      check(tick_o == 1'b0, "R3 tick in reset", int'(tick_o), 0);
      check(ch_o == CH_W'(NUM_CH - 1), "R3 channel in reset", int'(ch_o), NUM_CH - 1);
    end
    rst_n = 1'b1;
  endtask

  // Run v visits per channel; optionally change channel 0's divisor after visit chg_at.
  task automatic run(input int v, input int chg_at, input int chg_val);
    int vis0;
    rot_err = 0;
    vis0 = 0;
    for (int c = 0; c < NUM_CH; c++) begin
      tick_cnt[c] = 0;
      first_tick[c] = -1;
      for (int k = 0; k < MAXV; k++) ticks_at[c][k] = 1'b0;
    end
    for (int i = 0; i < v * NUM_CH; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (ch_o != CH_W'(i % NUM_CH)) rot_err++;  // R8 slot timing, R2 order
      if (tick_o) begin
        tick_cnt[ch_o]++;
        if (first_tick[ch_o] < 0) first_tick[ch_o] = i / NUM_CH;
        if (i / NUM_CH < MAXV) ticks_at[ch_o][i / NUM_CH] = 1'b1;
      end
      if (ch_o == '0) begin
        if (vis0 == chg_at) set_div(0, chg_val);
        vis0++;
      end
    end
    check(rot_err == 0, "R2 R8 channel order", rot_err, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // Table walk: R1 divide, R4 first enable, R6 zero divisor
    for (int t = 0; t < NV; t++) begin
      set_all(TV_DIV[t]);
      do_reset();
      run(TV_VIS[t], -1, 0);
      for (int c = 0; c < NUM_CH; c++)
        check(tick_cnt[c] == TV_CNT[t], "R1 R6 enable count", tick_cnt[c], TV_CNT[t]);
      check(first_tick[0] == TV_FIRST[t], "R4 first enable visit", first_tick[0], TV_FIRST[t]);
    end

    // R4, R6: divisor 0 -> visit 0 quiet, visits 1 and 2 fire
    set_all(0);
    do_reset();
    run(3, -1, 0);
    check(ticks_at[0][0] == 1'b0, "R4 visit0 quiet", int'(ticks_at[0][0]), 0);
    check(ticks_at[0][1] == 1'b1, "R6 visit1 fires", int'(ticks_at[0][1]), 1);
    check(ticks_at[0][2] == 1'b1, "R6 visit2 fires", int'(ticks_at[0][2]), 1);

    // R7: different divisors on each channel at once over 12 visits
    set_div(0, 1); set_div(1, 2); set_div(2, 3); set_div(3, 4);
    do_reset();
    run(12, -1, 0);
    check(tick_cnt[0] == 11, "R7 ch0 count", tick_cnt[0], 11);
    check(tick_cnt[1] == 5,  "R7 ch1 count", tick_cnt[1], 5);
    check(tick_cnt[2] == 3,  "R7 ch2 count", tick_cnt[2], 3);
    check(tick_cnt[3] == 2,  "R7 ch3 count", tick_cnt[3], 2);

    // R5: ch0 divisor 4 -> 2 after visit 8; visit 9 reloads quietly, fires at 11 and 13
    set_all(4);
    do_reset();
    run(15, 8, 2);
    check(ticks_at[0][4]  == 1'b1, "R5 old rate visit4",  int'(ticks_at[0][4]), 1);
    check(ticks_at[0][8]  == 1'b1, "R5 old rate visit8",  int'(ticks_at[0][8]), 1);
    check(ticks_at[0][9]  == 1'b0, "R5 reload visit9",    int'(ticks_at[0][9]), 0);
    check(ticks_at[0][10] == 1'b0, "R5 visit10 quiet",    int'(ticks_at[0][10]), 0);
    check(ticks_at[0][11] == 1'b1, "R5 new rate visit11", int'(ticks_at[0][11]), 1);
    check(ticks_at[0][12] == 1'b0, "R5 visit12 quiet",    int'(ticks_at[0][12]), 0);
    check(ticks_at[0][13] == 1'b1, "R5 new rate visit13", int'(ticks_at[0][13]), 1);
    check(tick_cnt[1] == 3, "R7 ch1 unaffected by ch0 change", tick_cnt[1], 3);

    // R4: reset mid-run clears counts; divisor 1 again quiet on visit 0
    set_all(1);
    do_reset();
    run(2, -1, 0);
    check(ticks_at[2][0] == 1'b0, "R4 quiet after re-reset", int'(ticks_at[2][0]), 0);
    check(ticks_at[2][1] == 1'b1, "R1 divisor1 fires visit1", int'(ticks_at[2][1]), 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule